// File: doc/BRIEF.md
# Four-Digit Character and Cursor Store

This block holds the host-written state of a four-position character display: one 7-bit character code per digit and one cursor flag per digit. A host drives it over an asynchronous, level-sensitive bus. The bus has two active-low chip enables, an active-low write strobe, a select line that picks the character store or the cursor store, an active-low clear line, a 2-bit digit address and a 7-bit data bus. Every bus input is brought into the system clock through a two-flop synchronizer. A write is committed once, when its strobe-low interval ends, using the last address, data and select values seen during that interval.

A scan engine reads both stores through a read port. It sets a digit address and gets back that digit's character code and cursor flag combinationally. Clear has priority over writes. A write whose strobe interval overlaps a clear is thrown away.

Top module: `dispmem_wport`

## Requirements
- R1: After reset every character entry reads 7'h20 (space) and every cursor flag reads 0.
- R2: A write interval with both enables low and `cur_sel_n` high stores `bus_data[6:0]` into the character entry addressed by `bus_addr`. Address 0 is the rightmost digit. The read port uses the same address encoding. The other entries are unchanged.
- R3: A write interval with both enables low and `cur_sel_n` low sets the addressed cursor flag to `bus_data[0]`. Bits 6..1 are ignored, and no character entry changes.
- R4: A strobe-low interval while either enable is high changes neither store.
- R5: Each strobe-low interval commits exactly once. It uses the address, data and select values present in its last synchronized cycle, so data that changes mid-interval is replaced by the final value.
- R6: Holding `clr_n` low for at least three clock cycles sets all character entries to 7'h20 and all cursor flags to 0.
- R7: A write interval that overlaps a clear, even partly, commits nothing. This holds even if the strobe is released after the clear ends.
- R8: Neither store changes while the strobe is still low. The commit becomes visible on the third rising clock edge after the strobe (or an enable) is released, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | First chip enable, active low, asynchronous |
| ce2_n | input | 1 | Second chip enable, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, level-sensitive |
| cur_sel_n | input | 1 | Low selects the cursor store, high selects the character store |
| clr_n | input | 1 | Clear of both stores, active low |
| bus_addr | input | 2 | Digit address, 0 is the rightmost digit |
| bus_data | input | 7 | Character code; bit 0 is the cursor value for cursor writes |
| rd_addr | input | 2 | Scan-side read address |
| rd_char | output | 7 | Character code of the digit at `rd_addr` |
| rd_cursor | output | 1 | Cursor flag of the digit at `rd_addr` |

## Verification
The bench changes the data bus in the middle of one strobe interval. A design that commits on the strobe's falling edge, or on every low cycle, would store the first value or store twice. It asserts clear in the middle of a strobe and releases the strobe later. A design that only masks the commit cycle would still write stale data. It writes a cursor with data 7'h7E and 7'h01 to show that only bit 0 counts and that the character entries stay untouched. It also samples the read port two and three edges after the strobe is released, which catches a synchronizer stage that is missing or added.

// File: rtl/dispmem_pkg.sv
package dispmem_pkg;
  localparam int DIGITS = 4;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 7;
  localparam logic [CODE_W-1:0] BLANK_CODE = 7'h20;

  typedef struct packed {
    logic              ce1_n;
    logic              ce2_n;
    logic              wr_n;
    logic              cur_sel_n;
    logic              clr_n;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] data;
  } bus_t;

  localparam int BUS_W = $bits(bus_t);

  // Write request: both enables and the strobe asserted (all active low).
  function automatic logic write_request(input logic ce1_n, input logic ce2_n,
                                         input logic wr_n);
    return !ce1_n && !ce2_n && !wr_n;
  endfunction

  // One-hot digit select for a commit.
  function automatic logic [DIGITS-1:0] digit_hit(input logic [ADDR_W-1:0] a);
    return DIGITS'(1) << a;
  endfunction
endpackage

// File: rtl/dispmem_sync.sv
module dispmem_sync #(
  parameter int               W       = 8,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[b]   <= RST_VAL[b];
        stable_q[b] <= RST_VAL[b];
      end else begin
        meta_q[b]   <= async_in[b];
        stable_q[b] <= meta_q[b];
      end
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/dispmem_wctl.sv
module dispmem_wctl
  import dispmem_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_t          bus_s,
  output logic          commit,
  output logic [AW-1:0] cmt_addr,
  output logic [CW-1:0] cmt_data,
  output logic          cmt_cursor,
  output logic          clr_act
);
  logic          req;
  logic          pend_q;
  logic          spoiled_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] data_q;
  logic          cursor_q;

  assign req     = write_request(bus_s.ce1_n, bus_s.ce2_n, bus_s.wr_n);
  assign clr_act = !bus_s.clr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      spoiled_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cursor_q  <= 1'b0;
    end else begin
      spoiled_q <= req && (spoiled_q || clr_act);
      if (clr_act || spoiled_q) begin
        pend_q <= 1'b0;
      end else if (req) begin
        pend_q   <= 1'b1;
        addr_q   <= bus_s.addr;
        data_q   <= bus_s.data;
        cursor_q <= !bus_s.cur_sel_n;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  assign commit     = pend_q && !req && !clr_act;
  assign cmt_addr   = addr_q;
  assign cmt_data   = data_q;
  assign cmt_cursor = cursor_q;

  // R5
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R8
  commit_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(req));
  // R7
  no_commit_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !pend_q);
endmodule

// File: rtl/dispmem_store.sv
module dispmem_store
  import dispmem_pkg::*;
#(
  parameter int                ND    = DIGITS,
  parameter int                AW    = ADDR_W,
  parameter int                CW    = CODE_W,
  parameter logic [CODE_W-1:0] BLANK = BLANK_CODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] cmt_addr,
  input  logic [CW-1:0] cmt_data,
  input  logic          cmt_cursor,
  input  logic          clr_act,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_char,
  output logic          rd_cursor
);
  logic [ND-1:0][CW-1:0] char_q;
  logic [ND-1:0]         cur_q;
  logic [ND-1:0]         hit;
  logic [ND*CW-1:0]      char_flat;
  logic                  char_we;
  logic                  cur_we;

  assign hit       = digit_hit(cmt_addr);
  assign char_we   = commit && !clr_act && !cmt_cursor;
  assign cur_we    = commit && !clr_act && cmt_cursor;
  assign char_flat = char_q;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [CW-1:0] slot_q;
    logic          cflag_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clr_act) begin
        slot_q  <= BLANK;
        cflag_q <= 1'b0;
      end else begin
        if (char_we && hit[i]) slot_q  <= cmt_data;
        if (cur_we && hit[i])  cflag_q <= cmt_data[0];
      end
    end

    assign char_q[i] = slot_q;
    assign cur_q[i]  = cflag_q;

    // R2
    char_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !cmt_cursor && !clr_act && cmt_addr == AW'(i))
        |=> slot_q == $past(cmt_data));
    // R6
    clear_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> (slot_q == BLANK) && !cflag_q);
  end

  assign rd_char   = char_q[rd_addr];
  assign rd_cursor = cur_q[rd_addr];

  // R3
  cursor_keeps_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmt_cursor) |=> $stable(char_flat));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !clr_act) |=> ($stable(char_flat) && $stable(cur_q)));
endmodule

// File: rtl/dispmem_wport.sv
module dispmem_wport
  import dispmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              wr_n,
  input  logic              cur_sel_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CODE_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CODE_W-1:0] rd_char,
  output logic              rd_cursor
);
  localparam bus_t BUS_IDLE = '{ce1_n: 1'b1, ce2_n: 1'b1, wr_n: 1'b1,
                                cur_sel_n: 1'b1, clr_n: 1'b1,
                                addr: '0, data: '0};

  bus_t              bus_raw;
  bus_t              bus_s;
  logic              commit;
  logic [ADDR_W-1:0] cmt_addr;
  logic [CODE_W-1:0] cmt_data;
  logic              cmt_cursor;
  logic              clr_act;

  assign bus_raw = '{ce1_n: ce1_n, ce2_n: ce2_n, wr_n: wr_n,
                     cur_sel_n: cur_sel_n, clr_n: clr_n,
                     addr: bus_addr, data: bus_data};

  dispmem_sync #(.W(BUS_W), .RST_VAL(BUS_IDLE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (bus_raw),
    .sync_out (bus_s)
  );

  dispmem_wctl u_wctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_s      (bus_s),
    .commit     (commit),
    .cmt_addr   (cmt_addr),
    .cmt_data   (cmt_data),
    .cmt_cursor (cmt_cursor),
    .clr_act    (clr_act)
  );

  dispmem_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .cmt_addr   (cmt_addr),
    .cmt_data   (cmt_data),
    .cmt_cursor (cmt_cursor),
    .clr_act    (clr_act),
    .rd_addr    (rd_addr),
    .rd_char    (rd_char),
    .rd_cursor  (rd_cursor)
  );
endmodule

// File: tb/dispmem_wport_test.sv
module dispmem_wport_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce1_n, ce2_n, wr_n, cur_sel_n, clr_n;
  logic [1:0] bus_addr;
  logic [6:0] bus_data;
  logic [1:0] rd_addr;
  logic [6:0] rd_char;
  logic       rd_cursor;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [6:0] exp_char [4];
  logic       exp_cur  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dispmem_wport uut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .wr_n(wr_n),
    .cur_sel_n(cur_sel_n), .clr_n(clr_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .rd_addr(rd_addr), .rd_char(rd_char),
    .rd_cursor(rd_cursor)
  );

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_digit(input int d, input string req);
    rd_addr = 2'(d);
    #1;
    checks++;
    if (rd_char !== exp_char[d] || rd_cursor !== exp_cur[d]) begin
      failures++;
      $display("FAIL %s digit %0d: got char=%h cur=%b expected char=%h cur=%b",
               req, d, rd_char, rd_cursor, exp_char[d], exp_cur[d]);
    end
  endtask

  task automatic check_all(input string req);
    for (int d = 0; d < 4; d++) check_digit(d, req);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [6:0] v,
                           input logic to_cursor, input logic c1, input logic c2);
    ce1_n = c1; ce2_n = c2; bus_addr = a; bus_data = v; cur_sel_n = !to_cursor;
    wr_n = 1'b0;
    cycles(4);
    wr_n = 1'b1;
    cycles(1);
    ce1_n = 1'b1; ce2_n = 1'b1;
    cycles(4);
  endtask

  task automatic test_reset;
    for (int d = 0; d < 4; d++) begin exp_char[d] = 7'h20; exp_cur[d] = 1'b0; end
    check_all("R1");
  endtask

  task automatic test_char_writes;
    bus_write(2'd0, 7'h41, 1'b0, 1'b0, 1'b0); exp_char[0] = 7'h41;
    bus_write(2'd3, 7'h5A, 1'b0, 1'b0, 1'b0); exp_char[3] = 7'h5A;
    bus_write(2'd1, 7'h7F, 1'b0, 1'b0, 1'b0); exp_char[1] = 7'h7F;
    check_all("R2");
  endtask

  task automatic test_cursor_writes;
    bus_write(2'd2, 7'h01, 1'b1, 1'b0, 1'b0); exp_cur[2] = 1'b1;
    check_all("R3");
    bus_write(2'd1, 7'h7E, 1'b1, 1'b0, 1'b0);
    check_all("R3");
    bus_write(2'd2, 7'h7E, 1'b1, 1'b0, 1'b0); exp_cur[2] = 1'b0;
    bus_write(2'd0, 7'h01, 1'b1, 1'b0, 1'b0); exp_cur[0] = 1'b1;
    check_all("R3");
  endtask

  task automatic test_enables;
    bus_write(2'd0, 7'h11, 1'b0, 1'b1, 1'b0);
    bus_write(2'd3, 7'h12, 1'b0, 1'b0, 1'b1);
    bus_write(2'd1, 7'h00, 1'b1, 1'b1, 1'b1);
    check_all("R4");
  endtask

  task automatic test_midstrobe_change;
    ce1_n = 1'b0; ce2_n = 1'b0; cur_sel_n = 1'b1; bus_addr = 2'd2;
    bus_data = 7'h33; wr_n = 1'b0;
    cycles(4);
    bus_data = 7'h44;
    cycles(4);
    wr_n = 1'b1;
    cycles(5);
    ce1_n = 1'b1; ce2_n = 1'b1;
    exp_char[2] = 7'h44;
    check_all("R5");
  endtask

  task automatic test_latency;
    ce1_n = 1'b0; ce2_n = 1'b0; cur_sel_n = 1'b1; bus_addr = 2'd3;
    bus_data = 7'h2A; wr_n = 1'b0;
    cycles(6);
    check_digit(3, "R8");
    wr_n = 1'b1;
    cycles(2);
    check_digit(3, "R8");
    cycles(1);
    exp_char[3] = 7'h2A;
    check_digit(3, "R8");
    ce1_n = 1'b1; ce2_n = 1'b1;
    cycles(4);
  endtask

  task automatic test_clear;
    clr_n = 1'b0;
    cycles(4);
    clr_n = 1'b1;
    cycles(4);
    for (int d = 0; d < 4; d++) begin exp_char[d] = 7'h20; exp_cur[d] = 1'b0; end
    check_all("R6");
  endtask

  task automatic test_clear_overlap;
    bus_write(2'd1, 7'h55, 1'b0, 1'b0, 1'b0); exp_char[1] = 7'h55;
    ce1_n = 1'b0; ce2_n = 1'b0; cur_sel_n = 1'b1; bus_addr = 2'd0;
    bus_data = 7'h66; wr_n = 1'b0;
    cycles(3);
    clr_n = 1'b0;
    cycles(4);
    clr_n = 1'b1;
    cycles(5);
    wr_n = 1'b1;
    cycles(1);
    ce1_n = 1'b1; ce2_n = 1'b1;
    cycles(5);
    for (int d = 0; d < 4; d++) begin exp_char[d] = 7'h20; exp_cur[d] = 1'b0; end
    check_all("R7");
    bus_write(2'd0, 7'h31, 1'b0, 1'b0, 1'b0); exp_char[0] = 7'h31;
    check_all("R7");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; ce1_n = 1'b1; ce2_n = 1'b1; wr_n = 1'b1; cur_sel_n = 1'b1;
    clr_n = 1'b1; bus_addr = '0; bus_data = '0; rd_addr = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(3);
    test_reset;
    test_char_writes;
    test_cursor_writes;
    test_enables;
    test_midstrobe_change;
    test_latency;
    test_clear;
    test_clear_overlap;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got running expected finished");
      finish_run;
    end
  end
endmodule